// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a synchronous binary counter built from 4-bit slices that can be preset from a parallel data word and chained into a wider counter. Every state bit is updated on the rising clock edge, so all outputs move together. Counting needs two enables. The parallel enable is shared by every slice. The chain enable enters the lowest slice. Each slice passes its carry forward as the chain enable of the slice above. The carry out of the top slice can enable a further counter.

An active-low clear forces the count to zero at once, without waiting for a clock edge. Its release is synchronized to the clock, so the counter resumes on a clean edge. A low level on the load input copies the data word into the count on the next edge. Load takes priority over counting, and the enables have no say in it. Between edges, changes on the control inputs have no effect on the stored count. The number of slices is a parameter, and the default is two slices, which gives an 8-bit count.

Top module: `casc_counter`

## Requirements
- R1: While `clr_n` is low, `q` is 0 and `carry_out` is 0. This takes effect immediately, also between clock edges, whatever the levels of `ld_n`, `en_par`, `en_chain` and the clock.
- R2: After `clr_n` returns high, `q` stays 0 over the first two rising edges. The third rising edge is the first that can load or count.
- R3: When `ld_n` is low at a rising edge, `q` takes the value of `din` at that edge, whatever the enables. Any value from 0 to all ones can be preset.
- R4: When `ld_n`, `en_par` and `en_chain` are all high at a rising edge, `q` increases by one. It wraps from all ones to 0.
- R5: When `ld_n` is high and either `en_par` or `en_chain` is low at a rising edge, `q` keeps its value.
- R6: `carry_out` is 1 exactly when `en_chain` is 1 and `q` is all ones. It is combinational and follows `en_chain` between edges.
- R7: Within the wide count, a slice advances only on an edge where every lower slice is all ones. For example, 0x0F counts to 0x10, and 0x10 holds while `en_par` is low.
- R8: A change on `ld_n`, `din` or the enables that is undone before the next rising edge leaves `q` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Active-low clear; asserts asynchronously, release synchronized |
| ld_n | input | 1 | Active-low synchronous parallel load |
| din | input | 4*STAGES | Preset data word |
| en_par | input | 1 | Parallel count enable shared by all slices |
| en_chain | input | 1 | Chain count enable into the lowest slice; also gates `carry_out` |
| q | output | 4*STAGES | Current count |
| carry_out | output | 1 | High when `en_chain` is high and `q` is all ones |

## Verification
A load, count or hold shows on `q` one edge after the inputs are applied. The bench drives the inputs, waits for that rising edge, and samples 2 ns later, well before the next edge. The clear and the carry output are combinational paths, so the bench samples them 1 ns after changing the input, with no edge in between. The clear release is checked edge by edge: the bench expects zero after the first two edges and the first increment after the third.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  localparam int unsigned SLICE_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2
  } cnt_op_e;

endpackage

// File: rtl/clr_release_sync.sv
module clr_release_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic clr_n,
  output logic rst_q
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic [SYNC_STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_q = chain_q[SYNC_STAGES-1];

endmodule

// File: rtl/cnt_slice.sv
module cnt_slice
  import cnt_pkg::*;
#(
  parameter int unsigned W = SLICE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_n,
  input  logic         en_par,
  input  logic         en_in,
  input  logic [W-1:0] din,
  output logic [W-1:0] q,
  output logic         carry
);

  cnt_op_e      op;
  logic [W-1:0] q_d;
  logic [W-1:0] cnt_q;

  always_comb begin
    if (!ld_n) begin
      op = OP_LOAD;
    end else if (en_par && en_in) begin
      op = OP_COUNT;
    end else begin
      op = OP_HOLD;
    end
  end

  always_comb begin
    unique case (op)
      OP_LOAD:  q_d = din;
      OP_COUNT: q_d = cnt_q + 1'b1;
      default:  q_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= q_d;
    end
  end

  assign q     = cnt_q;
  assign carry = en_in & (&cnt_q);

endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int unsigned STAGES      = 2,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TOTAL_W    = STAGES * SLICE_W
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               ld_n,
  input  logic [TOTAL_W-1:0] din,
  input  logic               en_par,
  input  logic               en_chain,
  output logic [TOTAL_W-1:0] q,
  output logic               carry_out
);

  logic              rst_q;
  logic              rst_n_mix;
  logic [STAGES:0]   chain_en;

  clr_release_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .clr_n (clr_n),
    .rst_q (rst_q)
  );

  // The clear acts at once; only its release waits for the synchronizer.
  assign rst_n_mix   = rst_q & clr_n;
  assign chain_en[0] = en_chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_slice
    cnt_slice #(
      .W(SLICE_W)
    ) u_slice (
      .clk    (clk),
      .rst_n  (rst_n_mix),
      .ld_n   (ld_n),
      .en_par (en_par),
      .en_in  (chain_en[s]),
      .din    (din[s*SLICE_W +: SLICE_W]),
      .q      (q[s*SLICE_W +: SLICE_W]),
      .carry  (chain_en[s+1])
    );
  end

  assign carry_out = chain_en[STAGES];

endmodule

// File: rtl/casc_counter_chk.sv
module casc_counter_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic         rst_q,
  input logic         ld_n,
  input logic [W-1:0] din,
  input logic         en_par,
  input logic         en_chain,
  input logic [W-1:0] q,
  input logic         carry_out
);

  // R1
  clear_zero_chk: assert property (@(posedge clk) !clr_n |-> (q == '0) && !carry_out);

  // R2
  release_hold_chk: assert property (@(posedge clk) disable iff (!clr_n)
    !rst_q |=> (q == '0));

  // R3
  load_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !ld_n |=> (q == $past(din)));

  // R4
  count_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ld_n && en_par && en_chain) |=> (q == $past(q) + 1'b1));

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (ld_n && !(en_par && en_chain)) |=> $stable(q));

  // R6
  carry_chk: assert property (@(posedge clk) disable iff (!clr_n)
    carry_out == (en_chain && (&q)));

endmodule

bind casc_counter casc_counter_chk #(.W(TOTAL_W)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .rst_q     (rst_q),
  .ld_n      (ld_n),
  .din       (din),
  .en_par    (en_par),
  .en_chain  (en_chain),
  .q         (q),
  .carry_out (carry_out)
);

// File: tb/tb_casc_counter.sv
`timescale 1ns/1ps
module tb_casc_counter;

  localparam int W = 8;

  logic         clk;
  logic         clr_n;
  logic         ld_n;
  logic [W-1:0] din;
  logic         en_par;
  logic         en_chain;
  logic [W-1:0] q;
  logic         carry_out;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  casc_counter #(.STAGES(2)) dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .din(din),
    .en_par(en_par), .en_chain(en_chain), .q(q), .carry_out(carry_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic         ld_n;
    logic         enp;
    logic         ent;
    logic [W-1:0] din;
    logic [W-1:0] eq;
    logic         ec;
  } vec_t;

  // Applied one per edge, starting from a cleared count.
  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b0, 1'b0, 8'h0C, 8'h0C, 1'b0}, // R3 load, enables low
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h0D, 1'b0}, // R4 count
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h0D, 1'b0}, // R5 hold, en_par low
    '{1'b1, 1'b1, 1'b0, 8'h00, 8'h0D, 1'b0}, // R5 hold, en_chain low
    '{1'b0, 1'b1, 1'b1, 8'hFE, 8'hFE, 1'b0}, // R3 load beats count
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 1'b1}, // R4 R6 all ones
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0}, // R4 wrap
    '{1'b0, 1'b0, 1'b0, 8'h0F, 8'h0F, 1'b0}, // R3
    '{1'b1, 1'b1, 1'b1, 8'h00, 8'h10, 1'b0}, // R7 slice carry
    '{1'b1, 1'b0, 1'b1, 8'hAA, 8'h10, 1'b0}, // R7 hold
    '{1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, 1'b0}, // R3 R6 ent low
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'hFF, 1'b1}  // R6 ent high
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic apply(input logic l, input logic p, input logic t, input logic [W-1:0] d);
    ld_n = l; en_par = p; en_chain = t; din = d;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] model;
    clr_n = 1'b0;
    apply(1'b1, 1'b1, 1'b1, 8'h00);
    #1;
    chk("R1 reset q", q, 8'h00);
    chk("R1 reset carry", {7'b0, carry_out}, 8'h00);
    repeat (3) @(posedge clk);
    #2 clr_n = 1'b1;
    // R2: release, then two held edges
    @(posedge clk); #2 chk("R2 edge1", q, 8'h00);
    @(posedge clk); #2 chk("R2 edge2", q, 8'h00);
    @(posedge clk); #2 chk("R2 edge3", q, 8'h01);
    // return to 0 for the table
    apply(1'b0, 1'b0, 1'b0, 8'h00);
    @(posedge clk); #2;

    for (int i = 0; i < 12; i++) begin
      apply(VEC[i].ld_n, VEC[i].enp, VEC[i].ent, VEC[i].din);
      @(posedge clk); #2;
      chk($sformatf("R3/R4/R5/R7 vec%0d q", i), q, VEC[i].eq);
      chk($sformatf("R6 vec%0d carry", i), {7'b0, carry_out}, {7'b0, VEC[i].ec});
    end

    // R6: carry follows en_chain with no edge (q is FF, en_par low)
    apply(1'b1, 1'b0, 1'b0, 8'h00);
    #1 chk("R6 ent fall", {7'b0, carry_out}, 8'h00);
    en_chain = 1'b1;
    #1 chk("R6 ent rise", {7'b0, carry_out}, 8'h01);
    @(posedge clk); #2;

    // R8: glitch on load and enables undone before the edge
    ld_n = 1'b0; din = 8'h33; en_par = 1'b1;
    #1 chk("R8 no immediate change", q, 8'hFF);
    ld_n = 1'b1; en_par = 1'b0;
    @(posedge clk); #2 chk("R8 after edge", q, 8'hFF);

    // R1: clear in mid-cycle after a load
    apply(1'b0, 1'b0, 1'b0, 8'h5A);
    @(posedge clk); #2 chk("R3 load 5A", q, 8'h5A);
    clr_n = 1'b0;
    #1 chk("R1 async clear q", q, 8'h00);
    chk("R1 async clear carry", {7'b0, carry_out}, 8'h00);
    apply(1'b0, 1'b1, 1'b1, 8'hC3);
    @(posedge clk); #2 chk("R1 clear beats load", q, 8'h00);
    clr_n = 1'b1;
    apply(1'b1, 1'b1, 1'b1, 8'h00);
    @(posedge clk); #2 chk("R2 held1", q, 8'h00);
    @(posedge clk); #2 chk("R2 held2", q, 8'h00);

    // R4 R7: long run against a model, through the full wrap
    model = 8'h00;
    for (int n = 0; n < 300; n++) begin
      @(posedge clk); #2;
      model = model + 1'b1;
      chk("R4 R7 run", q, model);
    end

    done = 1'b1;
    finish_run();
  end

endmodule